// File: doc/BRIEF.md
# Slow-Clock Real-Time Counter

This block is a 24-bit counter that advances from a slow tick enable, not from the system clock. A 12-bit prescaler divides the tick rate. Four compare channels watch the count. Software drives the block through a small register file on the system clock:

- one-shot task bits that start, stop, clear or pre-load the counter;
- sticky event flags for ticks, wrap-around and compare matches;
- a write-1-to-set and a write-1-to-clear register for the interrupt enables.

A pre-load task puts the counter one step before wrap-around. Software can then exercise its wrap handling without waiting through 2^24 increments. A single registered interrupt line is raised while any event flag is set and its enable bit is also set.

Any bus master with a single-cycle write strobe and a read strobe can use the block. Read data returns one cycle after the read strobe.

Top module: `slowcnt_rtc`

## Requirements
- R1: After reset the counter is 0 and stopped, the prescaler is 0, and all event flags, enable bits, the interrupt and the read data are 0.
- R2: While running, the counter increments once per (P+1) cycles with tick_en high, where P is the prescaler. P is held at address 9 (12 bits). A value written there takes effect only in cycles where the counter is stopped; a running counter keeps the value it started with.
- R3: A write to address 0 issues tasks: bit 0 start, bit 1 stop, bit 2 clear to zero, bit 3 overflow pre-load. Tasks act at the clock edge of the write, in any state. Stop wins over start, and clear wins over pre-load. No increment happens in a cycle that carries a task write. Reading address 0 returns the running state in bit 0.
- R4: The pre-load task sets the counter to 0xFFFFFF, so the next increment wraps it to 0.
- R5: The overflow flag (address 2) sets on the increment that wraps 0xFFFFFF to 0.
- R6: The tick flag (address 1) sets on every increment.
- R7: Compare flag i (address 3+i) sets on an increment whose new count equals compare value i (address 11+i, 24 bits).
- R8: Event flags stay set until software writes them with bit 0 equal to 0. Writing bit 0 equal to 1 has no effect. A hardware set in the same cycle as a clear wins.
- R9: Address 7 sets enable bits and address 8 clears them, both write-1. Enable bit 0 is tick, bit 1 is overflow and bit 2+i is compare i. Both addresses read back the enable mask.
- R10: irq is the OR over all events of (flag AND enable). It changes at the same edge as the flags and enables that cause it.
- R11: Read data for bus_addr appears on bus_rdata in the cycle after bus_re is high. The counter value (address 10) is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow-clock tick, one system cycle wide |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | AW (4) | Register word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
A task write, an increment and the resulting flag all land at the same clock edge. The interrupt follows at that same edge. Read data is due one edge after the read strobe. The reference model in the bench applies these rules at each rising edge: it updates its state, then captures the value a read returns at that edge. The bench compares irq, and any pending read data, at the falling edge that follows. Stimulus also changes only at falling edges, so every comparison sees values that were settled a half period earlier.

// File: rtl/slowcnt_pkg.sv
package slowcnt_pkg;
  // Task bits as written to the task address: bit0 start .. bit3 pre-load
  typedef struct packed {
    logic trig;
    logic clr;
    logic stop;
    logic start;
  } task_t;

  localparam int EV_TICK = 0;
  localparam int EV_OVF  = 1;
  localparam int EV_CMP0 = 2;
endpackage

// File: rtl/slowcnt_presc.sv
module slowcnt_presc #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          restart,
  input  logic          run_q,
  input  logic [PW-1:0] presc_reg,
  output logic          hit
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] act_q;

  assign hit = adv && (pre_q == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (!run_q) act_q <= presc_reg;
      if (restart)  pre_q <= '0;
      else if (adv) pre_q <= hit ? '0 : pre_q + 1'b1;
    end
  end

  // R2: divisor frozen while running
  assert_presc_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    run_q |=> (act_q == $past(act_q)));

  // R2: phase never passes divisor while running
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (pre_q <= act_q));
endmodule

// File: rtl/slowcnt_core.sv
module slowcnt_core import slowcnt_pkg::*; #(
  parameter int CW   = 24,
  parameter int NCMP = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  task_t                     tsk,
  input  logic                      inc,
  input  logic [NCMP-1:0][CW-1:0]   cmp_val,
  output logic [CW-1:0]             cnt_q,
  output logic                      run_q,
  output logic                      ovf_hit,
  output logic [NCMP-1:0]           cmp_hit
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_inc;
  assign cnt_inc = cnt_q + 1'b1;
  assign ovf_hit = inc && (cnt_q == CNT_MAX);

  generate
    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
      assign cmp_hit[g] = inc && (cnt_inc == cmp_val[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (tsk.stop)       run_q <= 1'b0;
      else if (tsk.start) run_q <= 1'b1;
      if (tsk.clr)        cnt_q <= '0;
      else if (tsk.trig)  cnt_q <= CNT_MAX;
      else if (inc)       cnt_q <= cnt_inc;
    end
  end

  // R4: count moves only by one step, a clear or a pre-load
  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_q) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0) || (cnt_q == CNT_MAX)));

  // R3: stopped with no task, count holds
  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!run_q && (tsk == '0)) |=> $stable(cnt_q));

  // R5: increment at maximum lands on zero
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && (cnt_q == CNT_MAX)) |=> (cnt_q == '0));
endmodule

// File: rtl/slowcnt_evt.sv
module slowcnt_evt #(
  parameter int NEV = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev_set,
  input  logic [NEV-1:0] ev_swclr,
  input  logic [NEV-1:0] en_set,
  input  logic [NEV-1:0] en_clr,
  output logic [NEV-1:0] evt_q,
  output logic [NEV-1:0] en_q,
  output logic           irq_q
);
  logic [NEV-1:0] evt_d;
  logic [NEV-1:0] en_d;

  always_comb begin
    evt_d = (evt_q & ~ev_swclr) | ev_set;
    en_d  = (en_q | en_set) & ~en_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      en_q  <= en_d;
      irq_q <= |(evt_d & en_d);
    end
  end

  generate
    for (genvar g = 0; g < NEV; g++) begin : g_chk
      // R8: a flag rises only from a hardware set
      assert_flag_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_q[g]) |-> $past(ev_set[g]));
      // R8: a flag falls only from a software clear
      assert_flag_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(evt_q[g]) |-> $past(ev_swclr[g]));
    end
  endgenerate

  // R10: interrupt tracks masked flags
  assert_irq_match_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|(evt_q & en_q)));
endmodule

// File: rtl/slowcnt_rtc.sv
module slowcnt_rtc import slowcnt_pkg::*; #(
  parameter int CW   = 24,
  parameter int PW   = 12,
  parameter int NCMP = 4,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int NEV     = EV_CMP0 + NCMP;
  localparam int A_TASK  = 0;
  localparam int A_EVT   = 1;
  localparam int A_ISET  = A_EVT + NEV;
  localparam int A_ICLR  = A_ISET + 1;
  localparam int A_PRESC = A_ICLR + 1;
  localparam int A_CNT   = A_PRESC + 1;
  localparam int A_CMPV  = A_CNT + 1;

  task_t                    tsk;
  logic                     run_q;
  logic                     inc;
  logic                     adv;
  logic                     restart;
  logic                     ovf_hit;
  logic [NCMP-1:0]          cmp_hit;
  logic [CW-1:0]            cnt_q;
  logic [PW-1:0]            presc_q;
  logic [NCMP-1:0][CW-1:0]  cmp_q;
  logic [NEV-1:0]           ev_set, ev_swclr, en_set, en_clr, evt_q, en_q;
  logic [DW-1:0]            rd_d;
  logic                     wdata_unused;

  assign wdata_unused = ^bus_wdata[DW-1:CW];

  assign tsk     = (bus_we && bus_addr == AW'(A_TASK)) ? task_t'(bus_wdata[3:0]) : '0;
  assign adv     = run_q && tick_en && (tsk == '0);
  assign restart = tsk.clr || tsk.trig || (tsk.start && !run_q);

  slowcnt_presc #(.PW(PW)) presc_i (
    .clk(clk), .rst(rst), .adv(adv), .restart(restart),
    .run_q(run_q), .presc_reg(presc_q), .hit(inc)
  );

  slowcnt_core #(.CW(CW), .NCMP(NCMP)) core_i (
    .clk(clk), .rst(rst), .tsk(tsk), .inc(inc), .cmp_val(cmp_q),
    .cnt_q(cnt_q), .run_q(run_q), .ovf_hit(ovf_hit), .cmp_hit(cmp_hit)
  );

  assign ev_set = {cmp_hit, ovf_hit, inc};

  always_comb begin
    for (int i = 0; i < NEV; i++)
      ev_swclr[i] = bus_we && (bus_addr == AW'(A_EVT + i)) && !bus_wdata[0];
    en_set = (bus_we && bus_addr == AW'(A_ISET)) ? bus_wdata[NEV-1:0] : '0;
    en_clr = (bus_we && bus_addr == AW'(A_ICLR)) ? bus_wdata[NEV-1:0] : '0;
  end

  slowcnt_evt #(.NEV(NEV)) evt_i (
    .clk(clk), .rst(rst), .ev_set(ev_set), .ev_swclr(ev_swclr),
    .en_set(en_set), .en_clr(en_clr), .evt_q(evt_q), .en_q(en_q), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      cmp_q   <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(A_PRESC)) presc_q <= bus_wdata[PW-1:0];
      for (int i = 0; i < NCMP; i++)
        if (bus_addr == AW'(A_CMPV + i)) cmp_q[i] <= bus_wdata[CW-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == AW'(A_TASK))  rd_d[0] = run_q;
    for (int i = 0; i < NEV; i++)
      if (bus_addr == AW'(A_EVT + i)) rd_d[0] = evt_q[i];
    if (bus_addr == AW'(A_ISET) || bus_addr == AW'(A_ICLR)) rd_d = DW'(en_q);
    if (bus_addr == AW'(A_PRESC)) rd_d = DW'(presc_q);
    if (bus_addr == AW'(A_CNT))   rd_d = DW'(cnt_q);
    for (int i = 0; i < NCMP; i++)
      if (bus_addr == AW'(A_CMPV + i)) rd_d = DW'(cmp_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_d;
  end

  // R11: a write to the count address while stopped leaves the count alone
  assert_count_ro_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(A_CNT) && !run_q) |=> $stable(cnt_q));
endmodule

// File: tb/slowcnt_rtc_tb_top.sv
`timescale 1ns/1ps
module slowcnt_rtc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slowcnt_rtc dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [23:0] m_cnt;
  logic [23:0] m_cmp [4];
  logic        m_run;
  int          m_pre;
  int          m_pact;
  int          m_presc;
  logic [5:0]  m_evt, m_en;
  logic        m_irq;
  logic [31:0] m_rd;
  logic        m_rdv;
  logic [3:0]  m_rda;

  function automatic logic [31:0] mread(input logic [3:0] a);
    if (a == 0) return {31'd0, m_run};
    if (a >= 1 && a <= 6) return {31'd0, m_evt[a-1]};
    if (a == 7 || a == 8) return {26'd0, m_en};
    if (a == 9) return 32'(m_presc);
    if (a == 10) return {8'd0, m_cnt};
    if (a >= 11 && a <= 14) return {8'd0, m_cmp[a-11]};
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a == 0) return "R3";
    if (a == 1) return "R6";
    if (a == 2) return "R5";
    if (a >= 3 && a <= 6) return "R8";
    if (a == 7 || a == 8) return "R9";
    if (a == 9 || a == 10) return "R2";
    if (a >= 11 && a <= 14) return "R7";
    return "R11";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_run = 0; m_pre = 0; m_pact = 0; m_presc = 0;
      m_evt = 0; m_en = 0; m_irq = 0; m_rd = 0; m_rdv = 0; m_rda = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    end else begin
      logic [3:0] t;
      logic inc;
      logic [23:0] nc;
      logic [5:0] setv;
      m_rdv = bus_re;
      m_rda = bus_addr;
      if (bus_re) m_rd = mread(bus_addr);
      t = (bus_we && bus_addr == 0) ? bus_wdata[3:0] : 4'd0;
      inc = 0;
      if (m_run && tick_en && t == 0) begin
        if (m_pre == m_pact) begin m_pre = 0; inc = 1; end
        else m_pre = m_pre + 1;
      end
      nc = m_cnt + 24'd1;
      setv = 0;
      if (inc) begin
        setv[0] = 1;
        if (m_cnt == 24'hFFFFFF) setv[1] = 1;
        for (int i = 0; i < 4; i++) if (nc == m_cmp[i]) setv[2+i] = 1;
      end
      if (t[2] || t[3] || (t[0] && !m_run)) m_pre = 0;
      if (!m_run) m_pact = m_presc;
      if (t[1]) m_run = 0; else if (t[0]) m_run = 1;
      if (t[2]) m_cnt = 0; else if (t[3]) m_cnt = 24'hFFFFFF; else if (inc) m_cnt = nc;
      if (bus_we && bus_addr >= 1 && bus_addr <= 6 && !bus_wdata[0]) m_evt[bus_addr-1] = 0;
      m_evt = m_evt | setv;
      if (bus_we && bus_addr == 7) m_en = m_en | bus_wdata[5:0];
      if (bus_we && bus_addr == 8) m_en = m_en & ~bus_wdata[5:0];
      if (bus_we && bus_addr == 9) m_presc = int'(bus_wdata[11:0]);
      if (bus_we && bus_addr >= 11 && bus_addr <= 14) m_cmp[bus_addr-11] = bus_wdata[23:0];
      m_irq = |(m_evt & m_en);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (irq !== m_irq) begin
        bad++;
        $display("FAIL R10 irq actual=%0b expected=%0b", irq, m_irq);
      end
      if (m_rdv) begin
        total++;
        if (bus_rdata !== m_rd) begin
          bad++;
          $display("FAIL %s R11 addr=%0d actual=%h expected=%h", tag_of(m_rda), m_rda, bus_rdata, m_rd);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0;
    total++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    irq_chk(1'b0, "R1");
    rd_chk(0, 0, "R1");
    rd_chk(10, 0, "R1");
    rd_chk(7, 0, "R1");
    rd_chk(1, 0, "R1");
    rd_chk(9, 0, "R1");
    // R2 divide by one
    wr(0, 1);
    ticks(5);
    rd_chk(10, 5, "R2");
    rd_chk(1, 1, "R6");
    // R2 divide by four, loaded while stopped
    wr(0, 2);
    wr(9, 3);
    wr(0, 1);
    ticks(8);
    rd_chk(10, 7, "R2");
    // R2 change while running ignored
    wr(9, 0);
    ticks(4);
    rd_chk(10, 8, "R2");
    rd_chk(0, 1, "R3");
    // R3 stop, then clear
    wr(0, 2);
    ticks(4);
    rd_chk(10, 8, "R3");
    rd_chk(0, 0, "R3");
    wr(0, 4);
    rd_chk(10, 0, "R3");
    // R8 sticky flags
    wr(1, 1);
    rd_chk(1, 1, "R8");
    wr(1, 0);
    rd_chk(1, 0, "R8");
    // R9 enables
    wr(7, 3);
    rd_chk(7, 3, "R9");
    rd_chk(8, 3, "R9");
    wr(8, 1);
    rd_chk(7, 2, "R9");
    irq_chk(1'b0, "R10");
    // R4 pre-load and wrap, R5 overflow flag
    wr(0, 8);
    rd_chk(10, 32'hFFFFFF, "R4");
    wr(0, 1);
    ticks(1);
    rd_chk(10, 0, "R4");
    rd_chk(2, 1, "R5");
    irq_chk(1'b1, "R10");
    // R7 compare channel 0
    wr(11, 3);
    wr(3, 0);
    wr(2, 0);
    wr(7, 4);
    irq_chk(1'b0, "R10");
    ticks(2);
    rd_chk(3, 0, "R7");
    ticks(1);
    rd_chk(10, 3, "R7");
    rd_chk(3, 1, "R7");
    irq_chk(1'b1, "R10");
    // R11 count is read-only
    wr(10, 32'h55);
    rd_chk(10, 3, "R11");
    // R3 tick in a task cycle does not count
    @(negedge clk); bus_we = 1; bus_addr = 0; bus_wdata = 1; tick_en = 1;
    @(negedge clk); bus_we = 0; tick_en = 0;
    rd_chk(10, 3, "R3");
    // R3 stop wins over start
    wr(0, 3);
    rd_chk(0, 0, "R3");
    // mixed traffic, checked against the model every cycle
    wr(0, 1);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      tick_en   = ($urandom % 3) == 0;
      bus_we    = ($urandom % 6) == 0;
      bus_re    = ($urandom % 3) == 0;
      bus_addr  = 4'($urandom % 15);
      bus_wdata = $urandom;
      if (bus_addr == 9) bus_wdata = bus_wdata & 32'h3;
    end
    @(negedge clk); bus_we = 0; bus_re = 0; tick_en = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule